// File: doc/BRIEF.md
# RV32 Register-Register Execute Unit with Multiply/Divide

This block is the combinational arithmetic stage for register-register instructions in a single-cycle RV32 core. Each cycle it receives the full 32-bit instruction word and two 32-bit operand values. It returns one 32-bit result in the same cycle. The operands are used exactly as presented, so an add of `x1` and `x2` yields the plain sum of the two operand inputs.

Base integer operations and the multiply/divide extension share one major opcode. The block looks at the function-7 field to decide which group an instruction belongs to, and then uses the function-3 field to pick the operation within that group. All eight multiply and divide operations are computed in one combinational pass. This includes the signed, unsigned and mixed-sign upper product halves, and the fixed results the architecture defines for a zero divisor and for signed overflow. Any instruction the block does not recognise produces zero.

Top module: `rv32im_rtype_exu`

## Requirements
- R1: Field positions are opcode = instr[6:0], funct3 = instr[14:12] and funct7 = instr[31:25]. The result is zero whenever the opcode is not 7'b0110011.
- R2: With funct7 = 7'h00, funct3 selects the operation: 0 add, 1 shift left logical, 2 set-less-than signed, 3 set-less-than unsigned, 4 xor, 5 shift right logical, 6 or, 7 and. The shift amount is op2[4:0] and the compare results are 0 or 1.
- R3: With funct7 = 7'h20, funct3 0 gives op1 - op2 and funct3 5 gives an arithmetic right shift by op2[4:0]. Every other funct3 value gives zero.
- R4: Any funct7 other than 7'h00, 7'h20 or 7'h01 gives zero.
- R5: With funct7 = 7'h01 and funct3 0 (multiply), the result is the low 32 bits of op1*op2.
- R6: With funct7 = 7'h01, funct3 1, 2 and 3 return the upper 32 bits of the 64-bit product. For funct3 1 both operands are signed. For funct3 2 op1 is signed and op2 is unsigned. For funct3 3 both operands are unsigned.
- R7: With funct7 = 7'h01, funct3 selects the division operation: 4 signed quotient, 5 unsigned quotient, 6 signed remainder, 7 unsigned remainder. Signed quotients round toward zero, and a signed remainder takes the sign of the dividend.
- R8: When the divisor is zero, both quotient forms return 32'hFFFFFFFF and both remainder forms return op1. This rule applies regardless of the dividend.
- R9: A signed division of 32'h80000000 by 32'hFFFFFFFF returns 32'h80000000 as the quotient and 0 as the remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| op1 | input | 32 | First source operand value |
| op2 | input | 32 | Second source operand value |
| result | output | 32 | Combinational result |

## Verification
Two special division rules can apply to the same operand pair: the zero-divisor rule and the most-negative-dividend handling. The bench provokes this by pairing a dividend of 32'h80000000 with a divisor of zero under all four division encodings. It then judges that the zero-divisor values win: all ones for the quotients and the unchanged dividend for the remainders. The bench also steps the divisor to 32'hFFFFFFFF while keeping the same dividend, which confirms that the overflow values appear only when the divisor really is minus one.

// File: rtl/rvm_pkg.sv
package rvm_pkg;
    localparam logic [6:0] OPC_REGREG = 7'b0110011;
    localparam logic [6:0] F7_PLAIN   = 7'h00;
    localparam logic [6:0] F7_ALT     = 7'h20;
    localparam logic [6:0] F7_MULDIV  = 7'h01;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_PLAIN  = 2'd1,
        CLS_ALT    = 2'd2,
        CLS_MULDIV = 2'd3
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;
        logic [2:0] f3;
    } dec_t;
endpackage

// File: rtl/rvm_decode.sv
module rvm_decode
    import rvm_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    dec_t dec_d;
    logic unused_fields;

    assign unused_fields = ^{instr[ILEN-1:32], instr[24:15], instr[11:7]};

    always_comb begin
        dec_d.f3  = instr[14:12];
        dec_d.cls = CLS_NONE;
        if (instr[6:0] == OPC_REGREG) begin
            unique case (instr[31:25])
                F7_PLAIN:  dec_d.cls = CLS_PLAIN;
                F7_ALT:    dec_d.cls = CLS_ALT;
                F7_MULDIV: dec_d.cls = CLS_MULDIV;
                default:   dec_d.cls = CLS_NONE;
            endcase
        end
    end

    assign dec = dec_d;
endmodule

// File: rtl/rvm_base_alu.sv
module rvm_base_alu #(
    parameter int XLEN = 32
) (
    input  logic            alt,
    input  logic [2:0]      f3,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] res_d;

    assign shamt = b[SHW-1:0];

    always_comb begin
        res_d = '0;
        if (!alt) begin
            unique case (f3)
                3'd0: res_d = a + b;
                3'd1: res_d = a << shamt;
                3'd2: res_d = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
                3'd3: res_d = {{(XLEN-1){1'b0}}, a < b};
                3'd4: res_d = a ^ b;
                3'd5: res_d = a >> shamt;
                3'd6: res_d = a | b;
                default: res_d = a & b;
            endcase
        end else begin
            unique case (f3)
                3'd0: res_d = a - b;
                3'd5: res_d = $unsigned($signed(a) >>> shamt);
                default: res_d = '0;
            endcase
        end
    end

    assign res = res_d;
endmodule

// File: rtl/rvm_mul.sv
module rvm_mul #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);
    localparam int PW = 2 * XLEN;

    logic            a_sgn_d, b_sgn_d;
    logic [PW-1:0]   a_x_d, b_x_d, prod_d;
    logic [XLEN-1:0] res_d;

    always_comb begin
        a_sgn_d = (sel == 2'd1) || (sel == 2'd2);
        b_sgn_d = (sel == 2'd1);
        a_x_d   = {{XLEN{a_sgn_d & a[XLEN-1]}}, a};
        b_x_d   = {{XLEN{b_sgn_d & b[XLEN-1]}}, b};
        prod_d  = a_x_d * b_x_d;
        res_d   = (sel == 2'd0) ? prod_d[XLEN-1:0] : prod_d[PW-1:XLEN];
    end

    assign res = res_d;

    always_comb begin
        if (sel == 2'd0 && b == '0)
            p_mul_zero_r5: assert (res == '0);
        if (sel == 2'd3 && b == {{(XLEN-1){1'b0}}, 1'b1})
            p_mulhu_one_r6: assert (res == '0);
    end
endmodule

// File: rtl/rvm_div.sv
module rvm_div #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] res
);
    localparam logic [XLEN-1:0] MIN_NEG = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        logic            sgn;
        logic            a_neg;
        logic            b_neg;
        logic            zero;
        logic [XLEN-1:0] a_mag;
        logic [XLEN-1:0] b_mag;
        logic [XLEN-1:0] q_mag;
        logic [XLEN-1:0] r_mag;
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] rem;
    } div_t;

    div_t s_d;

    always_comb begin
        s_d.sgn   = ~sel[0];
        s_d.a_neg = s_d.sgn & a[XLEN-1];
        s_d.b_neg = s_d.sgn & b[XLEN-1];
        s_d.zero  = (b == '0);
        s_d.a_mag = s_d.a_neg ? (~a + 1'b1) : a;
        s_d.b_mag = s_d.zero ? {{(XLEN-1){1'b0}}, 1'b1}
                             : (s_d.b_neg ? (~b + 1'b1) : b);
        s_d.q_mag = s_d.a_mag / s_d.b_mag;
        s_d.r_mag = s_d.a_mag % s_d.b_mag;
        if (s_d.zero) begin
            s_d.quo = '1;
            s_d.rem = a;
        end else begin
            s_d.quo = (s_d.a_neg ^ s_d.b_neg) ? (~s_d.q_mag + 1'b1) : s_d.q_mag;
            s_d.rem = s_d.a_neg ? (~s_d.r_mag + 1'b1) : s_d.r_mag;
        end
    end

    assign res = sel[1] ? s_d.rem : s_d.quo;

    always_comb begin
        if (sel == 2'd0 && a == MIN_NEG && b == '1)
            p_ovf_quo_r9: assert (res == MIN_NEG);
        if (sel == 2'd2 && a == MIN_NEG && b == '1)
            p_ovf_rem_r9: assert (res == '0);
        if (sel[1] == 1'b0 && b != '0 && a[XLEN-1] == 1'b0 && b[XLEN-1] == 1'b0)
            p_quo_bound_r7: assert (res <= a);
    end
endmodule

// File: rtl/rv32im_rtype_exu.sv
module rv32im_rtype_exu
    import rvm_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] op1,
    input  logic [XLEN-1:0] op2,
    output logic [XLEN-1:0] result
);
    dec_t            dec;
    logic [XLEN-1:0] base_res, mul_res, div_res, result_d;

    rvm_decode #(.ILEN(ILEN)) u_decode (
        .instr (instr),
        .dec   (dec)
    );

    rvm_base_alu #(.XLEN(XLEN)) u_base (
        .alt (dec.cls == CLS_ALT),
        .f3  (dec.f3),
        .a   (op1),
        .b   (op2),
        .res (base_res)
    );

    rvm_mul #(.XLEN(XLEN)) u_mul (
        .sel (dec.f3[1:0]),
        .a   (op1),
        .b   (op2),
        .res (mul_res)
    );

    rvm_div #(.XLEN(XLEN)) u_div (
        .sel (dec.f3[1:0]),
        .a   (op1),
        .b   (op2),
        .res (div_res)
    );

    always_comb begin
        unique case (dec.cls)
            CLS_PLAIN, CLS_ALT: result_d = base_res;
            CLS_MULDIV:         result_d = dec.f3[2] ? div_res : mul_res;
            default:            result_d = '0;
        endcase
    end

    assign result = result_d;

    always_comb begin
        if (instr[6:0] != OPC_REGREG)
            p_bad_opcode_r1: assert (result == '0);
        if (instr[6:0] == OPC_REGREG && instr[31:25] != F7_PLAIN
            && instr[31:25] != F7_ALT && instr[31:25] != F7_MULDIV)
            p_bad_funct7_r4: assert (result == '0);
        if (dec.cls == CLS_MULDIV && dec.f3[2] && !dec.f3[1] && op2 == '0)
            p_divzero_quo_r8: assert (result == '1);
        if (dec.cls == CLS_MULDIV && dec.f3[2] && dec.f3[1] && op2 == '0)
            p_divzero_rem_r8: assert (result == op1);
    end
endmodule

// File: tb/rv32im_rtype_exu_bench.sv
module rv32im_rtype_exu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] op1 = 32'h0;
    logic [31:0] op2 = 32'h0;
    logic [31:0] result;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rv32im_rtype_exu u_rv32im_rtype_exu (
        .instr  (instr),
        .op1    (op1),
        .op2    (op2),
        .result (result)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [6:0] opc);
        return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
    endfunction

    function automatic logic [31:0] ref_md(input logic [2:0] f3,
                                           input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (f3)
            3'd0: begin p = sa * sb; return p[31:0]; end
            3'd1: begin p = sa * sb; return p[63:32]; end
            3'd2: begin p = sa * longint'({32'h0, b}); return p[63:32]; end
            3'd3: begin p = {32'h0, a} * {32'h0, b}; return p[63:32]; end
            3'd4: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
                p = sa / sb; return p[31:0];
            end
            3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
            3'd6: begin
                if (b == 0) return a;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
                p = sa % sb; return p[31:0];
            end
            default: return (b == 0) ? a : a % b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (instr %h op1 %h op2 %h)",
                     req, got, exp, instr, op1, op2);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = i; op1 = a; op2 = b;
        #2;
    endtask

    task automatic t_reset_state;
        @(posedge rst_n);
        #2;
        chk("R1 idle", result, 32'h0);
    endtask

    task automatic t_opcode;
        apply(mk(7'h00, 3'd0, 7'b0010011), 32'd5, 32'd7);
        chk("R1", result, 32'h0);
        apply(mk(7'h01, 3'd0, 7'b0110111), 32'd5, 32'd7);
        chk("R1", result, 32'h0);
    endtask

    task automatic t_plain;
        apply(mk(7'h00, 3'd0, 7'b0110011), 32'd10, 32'd20);
        chk("R2 add", result, 32'd30);
        apply(mk(7'h00, 3'd1, 7'b0110011), 32'h0000_0003, 32'h0000_0024);
        chk("R2 sll", result, 32'h0000_0030);
        apply(mk(7'h00, 3'd2, 7'b0110011), 32'hFFFF_FFFF, 32'd1);
        chk("R2 slt", result, 32'd1);
        apply(mk(7'h00, 3'd3, 7'b0110011), 32'hFFFF_FFFF, 32'd1);
        chk("R2 sltu", result, 32'd0);
        apply(mk(7'h00, 3'd4, 7'b0110011), 32'hF0F0_1234, 32'h0FF0_FFFF);
        chk("R2 xor", result, 32'hFF00_EDCB);
        apply(mk(7'h00, 3'd5, 7'b0110011), 32'h8000_0000, 32'd31);
        chk("R2 srl", result, 32'h0000_0001);
        apply(mk(7'h00, 3'd6, 7'b0110011), 32'hF000_0000, 32'h0000_000F);
        chk("R2 or", result, 32'hF000_000F);
        apply(mk(7'h00, 3'd7, 7'b0110011), 32'hFF00_FF00, 32'h0F0F_0F0F);
        chk("R2 and", result, 32'h0F00_0F00);
    endtask

    task automatic t_alt;
        apply(mk(7'h20, 3'd0, 7'b0110011), 32'd3, 32'd5);
        chk("R3 sub", result, 32'hFFFF_FFFE);
        apply(mk(7'h20, 3'd5, 7'b0110011), 32'h8000_0000, 32'd4);
        chk("R3 sra", result, 32'hF800_0000);
        apply(mk(7'h20, 3'd4, 7'b0110011), 32'h1234_5678, 32'h1);
        chk("R3 unused funct3", result, 32'h0);
    endtask

    task automatic t_funct7;
        apply(mk(7'h02, 3'd0, 7'b0110011), 32'd9, 32'd9);
        chk("R4", result, 32'h0);
        apply(mk(7'h21, 3'd4, 7'b0110011), 32'd9, 32'd3);
        chk("R4", result, 32'h0);
    endtask

    task automatic t_mul;
        apply(mk(7'h01, 3'd0, 7'b0110011), 32'hFFFF_FFFD, 32'd7);
        chk("R5 mul", result, 32'hFFFF_FFEB);
        apply(mk(7'h01, 3'd1, 7'b0110011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R6 mulh", result, 32'h0);
        apply(mk(7'h01, 3'd2, 7'b0110011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R6 mulhsu", result, 32'hFFFF_FFFF);
        apply(mk(7'h01, 3'd3, 7'b0110011), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R6 mulhu", result, 32'hFFFF_FFFE);
        apply(mk(7'h01, 3'd1, 7'b0110011), 32'h8000_0000, 32'h8000_0000);
        chk("R6 mulh min", result, 32'h4000_0000);
    endtask

    task automatic t_div_signs;
        apply(mk(7'h01, 3'd4, 7'b0110011), 32'hFFFF_FFF9, 32'd2);
        chk("R7 div -7/2", result, 32'hFFFF_FFFD);
        apply(mk(7'h01, 3'd6, 7'b0110011), 32'hFFFF_FFF9, 32'd2);
        chk("R7 rem -7%2", result, 32'hFFFF_FFFF);
        apply(mk(7'h01, 3'd6, 7'b0110011), 32'd7, 32'hFFFF_FFFE);
        chk("R7 rem 7%-2", result, 32'd1);
        apply(mk(7'h01, 3'd5, 7'b0110011), 32'hFFFF_FFF9, 32'd2);
        chk("R7 divu", result, 32'h7FFF_FFFC);
        apply(mk(7'h01, 3'd7, 7'b0110011), 32'hFFFF_FFF9, 32'd2);
        chk("R7 remu", result, 32'd1);
    endtask

    task automatic t_div_zero;
        for (int f = 4; f < 8; f++) begin
            apply(mk(7'h01, 3'(f), 7'b0110011), 32'h8000_0000, 32'h0);
            chk("R8 min/0", result, (f < 6) ? 32'hFFFF_FFFF : 32'h8000_0000);
            apply(mk(7'h01, 3'(f), 7'b0110011), 32'h0000_1234, 32'h0);
            chk("R8 x/0", result, (f < 6) ? 32'hFFFF_FFFF : 32'h0000_1234);
        end
    endtask

    task automatic t_overflow;
        apply(mk(7'h01, 3'd4, 7'b0110011), 32'h8000_0000, 32'hFFFF_FFFF);
        chk("R9 div", result, 32'h8000_0000);
        apply(mk(7'h01, 3'd6, 7'b0110011), 32'h8000_0000, 32'hFFFF_FFFF);
        chk("R9 rem", result, 32'h0);
        apply(mk(7'h01, 3'd5, 7'b0110011), 32'h8000_0000, 32'hFFFF_FFFF);
        chk("R9 divu unaffected", result, 32'h0);
        apply(mk(7'h01, 3'd4, 7'b0110011), 32'h8000_0000, 32'hFFFF_FFFE);
        chk("R9 div by -2", result, 32'h4000_0000);
    endtask

    task automatic t_sweep;
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  f;
            logic [31:0] a, b;
            f = 3'(n % 8);
            a = $urandom;
            b = $urandom;
            if (n % 5 == 0) b = b >> 28;
            if (n % 7 == 0) a = {1'b1, a[30:0]};
            apply(mk(7'h01, f, 7'b0110011), a, b);
            chk((f < 3'd4) ? "R6 sweep mul" : "R7 sweep div", result, ref_md(f, a, b));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
    end

    initial begin
        t_reset_state();
        t_opcode();
        t_plain();
        t_alt();
        t_funct7();
        t_mul();
        t_div_signs();
        t_div_zero();
        t_overflow();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule